// File: doc/BRIEF.md
# Slot-addressed register decoder for a 32-channel digitizer

This block is the bus-facing slave of a 32-channel digitizer board. A host reaches it over a simplified synchronous A24/D16 bus. Each access carries a 24-bit address, a 6-bit access-type code (the address modifier), a direction bit, a 16-bit write word and a one-cycle strobe. The board answers only when the board-index nibble of the address equals its own `slot_id`. It then sorts the access into one of five kinds: a control write, a per-channel threshold write, a single-word read of one channel FIFO, a block-transfer read of the merged FIFO stream, or a read of the block-transfer word counter.

The control word does two jobs at once. Its low ten bits load the stored sample count. Two of its bits, 9 and 10, also fire one-cycle pulses: bit 9 clears the FIFOs and bit 10 clears every suppression threshold. The FIFO storage lives outside the block. The block only raises a read enable for the FIFO it selects. In the same cycle it takes that FIFO's presented word, and it returns the word with the acknowledge.

Top module: `vme_slot_slave`

## Requirements
- R1: An access is accepted only if address bits 23:20 are zero and bits 19:16 equal `slot_id`. Any other access gets no acknowledge, changes no register, raises no pulse and asserts no read enable.
- R2: Only modifier 0x3D (single access) and modifiers 0x3B and 0x3F (block transfer) are accepted. Block-transfer modifiers accept reads only. Any other combination gets no acknowledge and has no effect.
- R3: An accepted access raises `bus_ack` for exactly one cycle, in the cycle right after the one in which its strobe was sampled. Rejected accesses never raise it.
- R4: A write at offset 0x0000 with modifier 0x3D stores write bits 9:0 as `sample_count`. The count stays unchanged until the next such write.
- R5: In that control write, bit 9 gives a one-cycle `fifo_rst_pulse` and bit 10 gives a one-cycle `thr_rst_pulse`. Both pulses appear in the acknowledge cycle and neither is held.
- R6: A control write with bit 10 set clears all channel thresholds to zero, at the same edge that raises `thr_rst_pulse`.
- R7: A write at offset j×0x0100 (j = 1..32, low address byte zero) with modifier 0x3D stores write bits 9:0 as the threshold of channel j. Threshold j sits at bits (j-1)×10 +: 10 of `thresholds`. No other channel changes.
- R8: A read at offset j×0x0100 with modifier 0x3D raises only `chan_rd_en[j-1]`, for the strobe cycle alone. It returns the word on `chan_rd_data[(j-1)×16 +: 16]` in that cycle through `bus_rdata` with the acknowledge.
- R9: A read at offset 0x0100 with modifier 0x3B or 0x3F raises only `merged_rd_en`, for the strobe cycle. It returns the word on `merged_rd_data` in that cycle with the acknowledge.
- R10: A read at offset 0x0101 with modifier 0x3B or 0x3F returns how many merged-stream words have been read since reset or since the last FIFO-clearing control write.
- R11: At offset 0x0100 the block-transfer decode takes priority. With 0x3B or 0x3F the access reads the merged stream and leaves channel 1 untouched. With 0x3D the same address reaches channel 1.
- R12: After reset, `bus_ack` and both pulses are low, every threshold is zero, `sample_count` equals its reset parameter (600), and the block-transfer counter reads zero.
- R13: These accesses get no acknowledge and have no effect: an offset with a nonzero low byte, a channel number above 32, and a read at the control offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_id | input | 4 | Board index this slave answers to |
| bus_addr | input | 24 | Access address |
| bus_am | input | 6 | Address modifier (access-type code) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 16 | Write word |
| bus_strobe | input | 1 | One-cycle access request |
| bus_ack | output | 1 | Acknowledge, one cycle after an accepted strobe |
| bus_rdata | output | 16 | Read word, valid with `bus_ack` |
| sample_count | output | 10 | Stored sample count |
| fifo_rst_pulse | output | 1 | One-cycle FIFO clear |
| thr_rst_pulse | output | 1 | One-cycle threshold clear |
| thresholds | output | 320 | 32 thresholds of 10 bits, channel 1 lowest |
| chan_rd_en | output | 32 | Per-channel FIFO read enable |
| chan_rd_data | input | 512 | Per-channel FIFO head words, channel 1 lowest |
| merged_rd_en | output | 1 | Merged-stream read enable |
| merged_rd_data | input | 16 | Merged-stream head word |

## Verification
The decoder is driven with addresses that differ in a single field at a time: slot nibble, modifier, direction, channel field and low byte. An acknowledge or the lack of one then shows which field the decode really depends on. Threshold writes go to the first, a middle and the last channel with junk in the upper write bits, which separates a correct channel index and field mask from an off-by-one or a bus-wide store. Offset 0x0100 is read under all three modifiers to expose the priority order. Interleaved merged-stream reads, counter reads and control writes with and without bit 9 tell a counter that clears on the right bit from one that misses or over-counts.

// File: rtl/vme_dec_pkg.sv
package vme_dec_pkg;

    localparam logic [5:0]  AM_SINGLE    = 6'h3D;
    localparam logic [5:0]  AM_BLK_A     = 6'h3B;
    localparam logic [5:0]  AM_BLK_B     = 6'h3F;

    localparam logic [15:0] OFS_CTRL     = 16'h0000;
    localparam logic [15:0] OFS_BLK_DATA = 16'h0100;
    localparam logic [15:0] OFS_BLK_CNT  = 16'h0101;

    localparam int FIFO_CLR_BIT = 9;
    localparam int THR_CLR_BIT  = 10;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CTRL,
        ACC_THR_WR,
        ACC_CHAN_RD,
        ACC_BLK_DATA,
        ACC_BLK_CNT
    } acc_kind_t;

    typedef struct packed {
        acc_kind_t  kind;
        logic [7:0] chan;   // channel number, 1-based
    } acc_dec_t;

    function automatic logic is_blk_am(input logic [5:0] am);
        return (am == AM_BLK_A) || (am == AM_BLK_B);
    endfunction

    function automatic acc_dec_t decode_access(
        input logic [23:0] addr,
        input logic [5:0]  am,
        input logic        wr,
        input logic [3:0]  slot,
        input int          nch
    );
        acc_dec_t   d;
        logic [15:0] ofs;
        logic [7:0]  ch;
        d.kind = ACC_NONE;
        d.chan = '0;
        ofs    = addr[15:0];
        ch     = addr[15:8];
        if (addr[23:20] == 4'h0 && addr[19:16] == slot) begin
            if (is_blk_am(am)) begin
                if (!wr && ofs == OFS_BLK_DATA)
                    d.kind = ACC_BLK_DATA;
                else if (!wr && ofs == OFS_BLK_CNT)
                    d.kind = ACC_BLK_CNT;
            end else if (am == AM_SINGLE) begin
                if (ofs == OFS_CTRL) begin
                    if (wr)
                        d.kind = ACC_CTRL;
                end else if (addr[7:0] == 8'h00 && int'(ch) <= nch) begin
                    d.kind = wr ? ACC_THR_WR : ACC_CHAN_RD;
                    d.chan = ch;
                end
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/vme_addr_dec.sv
module vme_addr_dec
    import vme_dec_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic [23:0] addr,
    input  logic [5:0]  am,
    input  logic        wr,
    input  logic [3:0]  slot,
    output acc_dec_t    dec
);

    always_comb begin
        dec = decode_access(addr, am, wr, slot, NCH);
    end

endmodule

// File: rtl/vme_ctrl_regs.sv
module vme_ctrl_regs
    import vme_dec_pkg::*;
#(
    parameter int NCH      = 32,
    parameter int DW       = 16,
    parameter int TW       = 10,
    parameter int SCW      = 10,
    parameter int SC_RESET = 600
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            strobe,
    input  acc_dec_t        dec,
    input  logic [DW-1:0]   wdata,
    output logic [SCW-1:0]  sample_count,
    output logic            fifo_rst_pulse,
    output logic            thr_rst_pulse,
    output logic [NCH*TW-1:0] thr_flat
);

    logic ctrl_hit;
    logic thr_hit;
    logic thr_clear;

    assign ctrl_hit  = strobe && (dec.kind == ACC_CTRL);
    assign thr_hit   = strobe && (dec.kind == ACC_THR_WR);
    assign thr_clear = ctrl_hit && wdata[THR_CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_count   <= SCW'(SC_RESET);
            fifo_rst_pulse <= 1'b0;
            thr_rst_pulse  <= 1'b0;
        end else begin
            fifo_rst_pulse <= ctrl_hit && wdata[FIFO_CLR_BIT];
            thr_rst_pulse  <= thr_clear;
            if (ctrl_hit)
                sample_count <= wdata[SCW-1:0];
        end
    end

    for (genvar j = 0; j < NCH; j++) begin : g_thr
        always_ff @(posedge clk) begin
            if (rst)
                thr_flat[j*TW +: TW] <= '0;
            else if (thr_clear)
                thr_flat[j*TW +: TW] <= '0;
            else if (thr_hit && dec.chan == 8'(j + 1))
                thr_flat[j*TW +: TW] <= wdata[TW-1:0];
        end
    end

    AST_THR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        thr_rst_pulse |-> (thr_flat == '0)); // R6

    AST_PULSE_FROM_CTRL: assert property (@(posedge clk) disable iff (rst)
        !ctrl_hit |=> (!fifo_rst_pulse && !thr_rst_pulse)); // R5

endmodule

// File: rtl/vme_read_path.sv
module vme_read_path
    import vme_dec_pkg::*;
#(
    parameter int NCH = 32,
    parameter int DW  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  acc_dec_t          dec,
    input  logic              cnt_clear,
    input  logic [NCH*DW-1:0] chan_rd_data,
    input  logic [DW-1:0]     merged_rd_data,
    output logic [NCH-1:0]    chan_rd_en,
    output logic              merged_rd_en,
    output logic              ack,
    output logic [DW-1:0]     rdata
);

    logic [DW-1:0] blk_cnt;
    logic [DW-1:0] chan_word;
    logic [DW-1:0] read_word;
    logic          is_read;
    logic          accepted;

    for (genvar j = 0; j < NCH; j++) begin : g_ren
        assign chan_rd_en[j] = strobe && (dec.kind == ACC_CHAN_RD) &&
                               (dec.chan == 8'(j + 1));
    end

    assign merged_rd_en = strobe && (dec.kind == ACC_BLK_DATA);
    assign accepted     = strobe && (dec.kind != ACC_NONE);
    assign is_read      = (dec.kind == ACC_CHAN_RD) || (dec.kind == ACC_BLK_DATA) ||
                          (dec.kind == ACC_BLK_CNT);

    always_comb begin
        chan_word = '0;
        for (int j = 0; j < NCH; j++) begin
            if (dec.chan == 8'(j + 1))
                chan_word = chan_rd_data[j*DW +: DW];
        end
    end

    always_comb begin
        unique case (dec.kind)
            ACC_CHAN_RD:  read_word = chan_word;
            ACC_BLK_DATA: read_word = merged_rd_data;
            ACC_BLK_CNT:  read_word = blk_cnt;
            default:      read_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_cnt <= '0;
            ack     <= 1'b0;
            rdata   <= '0;
        end else begin
            ack   <= accepted;
            rdata <= (accepted && is_read) ? read_word : '0;
            if (cnt_clear)
                blk_cnt <= '0;
            else if (merged_rd_en)
                blk_cnt <= blk_cnt + 1'b1;
        end
    end

    AST_ONE_READ_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chan_rd_en, merged_rd_en})); // R8

endmodule

// File: rtl/vme_slot_slave.sv
module vme_slot_slave
    import vme_dec_pkg::*;
#(
    parameter int NCH      = 32,
    parameter int DW       = 16,
    parameter int TW       = 10,
    parameter int SCW      = 10,
    parameter int SC_RESET = 600
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        slot_id,
    input  logic [23:0]       bus_addr,
    input  logic [5:0]        bus_am,
    input  logic              bus_write,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_strobe,
    output logic              bus_ack,
    output logic [DW-1:0]     bus_rdata,
    output logic [SCW-1:0]    sample_count,
    output logic              fifo_rst_pulse,
    output logic              thr_rst_pulse,
    output logic [NCH*TW-1:0] thresholds,
    output logic [NCH-1:0]    chan_rd_en,
    input  logic [NCH*DW-1:0] chan_rd_data,
    output logic              merged_rd_en,
    input  logic [DW-1:0]     merged_rd_data
);

    acc_dec_t dec;
    logic     cnt_clear;

    assign cnt_clear = bus_strobe && (dec.kind == ACC_CTRL) && bus_wdata[FIFO_CLR_BIT];

    vme_addr_dec #(.NCH(NCH)) u_dec (
        .addr (bus_addr),
        .am   (bus_am),
        .wr   (bus_write),
        .slot (slot_id),
        .dec  (dec)
    );

    vme_ctrl_regs #(
        .NCH(NCH), .DW(DW), .TW(TW), .SCW(SCW), .SC_RESET(SC_RESET)
    ) u_regs (
        .clk            (clk),
        .rst            (rst),
        .strobe         (bus_strobe),
        .dec            (dec),
        .wdata          (bus_wdata),
        .sample_count   (sample_count),
        .fifo_rst_pulse (fifo_rst_pulse),
        .thr_rst_pulse  (thr_rst_pulse),
        .thr_flat       (thresholds)
    );

    vme_read_path #(.NCH(NCH), .DW(DW)) u_rd (
        .clk            (clk),
        .rst            (rst),
        .strobe         (bus_strobe),
        .dec            (dec),
        .cnt_clear      (cnt_clear),
        .chan_rd_data   (chan_rd_data),
        .merged_rd_data (merged_rd_data),
        .chan_rd_en     (chan_rd_en),
        .merged_rd_en   (merged_rd_en),
        .ack            (bus_ack),
        .rdata          (bus_rdata)
    );

    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && dec.kind != ACC_NONE) |=> bus_ack); // R3

    AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> $past(bus_strobe)); // R3

    AST_FOREIGN_SLOT: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && bus_addr[19:16] != slot_id) |=> !bus_ack); // R1

    AST_BAD_MODIFIER: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && bus_am != AM_SINGLE && bus_am != AM_BLK_A && bus_am != AM_BLK_B)
        |=> !bus_ack); // R2

    AST_BLK_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && !bus_write && is_blk_am(bus_am) &&
         bus_addr == {4'h0, slot_id, OFS_BLK_DATA})
        |-> (merged_rd_en && !chan_rd_en[0])); // R11

    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (rst)
        !(bus_strobe && bus_write) |=> $stable(sample_count)); // R4

endmodule

// File: tb/tb_vme_slot_slave.sv
module tb_vme_slot_slave;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 32;
    localparam int DW  = 16;
    localparam int TW  = 10;
    localparam logic [3:0] SLOT = 4'h6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [23:0]       bus_addr = '0;
    logic [5:0]        bus_am = '0;
    logic              bus_write = 1'b0;
    logic [DW-1:0]     bus_wdata = '0;
    logic              bus_strobe = 1'b0;
    logic              bus_ack;
    logic [DW-1:0]     bus_rdata;
    logic [9:0]        sample_count;
    logic              fifo_rst_pulse;
    logic              thr_rst_pulse;
    logic [NCH*TW-1:0] thresholds;
    logic [NCH-1:0]    chan_rd_en;
    logic [NCH*DW-1:0] chan_rd_data;
    logic              merged_rd_en;
    logic [DW-1:0]     merged_rd_data;
    logic [DW-1:0]     mcount = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic            r_ack, r_ack2, r_fp, r_fp2, r_tp, r_tp2, r_men;
    logic [NCH-1:0]  r_cen;
    logic [DW-1:0]   r_data, exp_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int j = 0; j < NCH; j++)
            chan_rd_data[j*DW +: DW] = 16'h5000 + 16'(j + 1) * 16'h0101;
    end
    assign merged_rd_data = 16'hA000 + mcount;
    always @(posedge clk) if (merged_rd_en) mcount <= mcount + 1'b1;

    vme_slot_slave dut (
        .clk(clk), .rst(rst), .slot_id(SLOT),
        .bus_addr(bus_addr), .bus_am(bus_am), .bus_write(bus_write),
        .bus_wdata(bus_wdata), .bus_strobe(bus_strobe), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .sample_count(sample_count),
        .fifo_rst_pulse(fifo_rst_pulse), .thr_rst_pulse(thr_rst_pulse),
        .thresholds(thresholds), .chan_rd_en(chan_rd_en),
        .chan_rd_data(chan_rd_data), .merged_rd_en(merged_rd_en),
        .merged_rd_data(merged_rd_data)
    );

    function automatic logic [23:0] adr(input logic [3:0] s, input logic [15:0] ofs);
        return {4'h0, s, ofs};
    endfunction

    function automatic logic [9:0] thr_of(input int ch);
        return thresholds[(ch-1)*TW +: TW];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [23:0] a,
                          input logic [5:0] am, input logic [15:0] wd);
        @(negedge clk);
        bus_write = wr; bus_addr = a; bus_am = am; bus_wdata = wd; bus_strobe = 1'b1;
        #1;
        r_cen = chan_rd_en; r_men = merged_rd_en; exp_m = merged_rd_data;
        @(negedge clk);
        bus_strobe = 1'b0;
        r_ack = bus_ack; r_data = bus_rdata; r_fp = fifo_rst_pulse; r_tp = thr_rst_pulse;
        @(negedge clk);
        r_ack2 = bus_ack; r_fp2 = fifo_rst_pulse; r_tp2 = thr_rst_pulse;
    endtask

    task automatic t_reset;
        chk("R12 ack", bus_ack, 0);
        chk("R12 pulses", {fifo_rst_pulse, thr_rst_pulse}, 0);
        chk("R12 sample_count", sample_count, 600);
        chk("R12 thresholds", (thresholds == '0), 1);
        access(0, adr(SLOT, 16'h0101), 6'h3B, 0);
        chk("R12 block counter", r_data, 0);
    endtask

    task automatic t_ctrl;
        access(1, adr(SLOT, 16'h0000), 6'h3D, 16'hF123);
        chk("R4 sample_count", sample_count, 10'h123);
        chk("R3 ack one cycle later", r_ack, 1);
        chk("R3 ack one cycle only", r_ack2, 0);
        chk("R5 no pulses bit9/10 clear", {r_fp, r_tp}, 0);
        access(1, adr(SLOT, 16'h0000), 6'h3D, 16'h0200);
        chk("R5 fifo pulse", r_fp, 1);
        chk("R5 fifo pulse not held", r_fp2, 0);
        chk("R5 thr pulse absent", r_tp, 0);
        chk("R4 bit9 in field", sample_count, 10'h200);
    endtask

    task automatic t_thr;
        access(1, adr(SLOT, 16'h0100), 6'h3D, 16'hFC55);
        access(1, adr(SLOT, 16'h1100), 6'h3D, 16'h0123);
        access(1, adr(SLOT, 16'h2000), 6'h3D, 16'h02AA);
        chk("R7 ch1", thr_of(1), 10'h055);
        chk("R7 ch17", thr_of(17), 10'h123);
        chk("R7 ch32", thr_of(32), 10'h2AA);
        chk("R7 ch2 untouched", thr_of(2), 0);
        chk("R7 ch31 untouched", thr_of(31), 0);
        access(1, adr(SLOT, 16'h0000), 6'h3D, 16'h0400);
        chk("R5 thr pulse", r_tp, 1);
        chk("R5 thr pulse not held", r_tp2, 0);
        chk("R5 fifo pulse absent", r_fp, 0);
        chk("R6 thresholds cleared", (thresholds == '0), 1);
    endtask

    task automatic t_chan_read;
        access(0, adr(SLOT, 16'h0500), 6'h3D, 0);
        chk("R8 enable ch5", r_cen, 32'h0000_0010);
        chk("R8 merged idle", r_men, 0);
        chk("R8 data ch5", r_data, 16'h5000 + 16'h0505);
        access(0, adr(SLOT, 16'h2000), 6'h3D, 0);
        chk("R8 enable ch32", r_cen, 32'h8000_0000);
        chk("R8 data ch32", r_data, 16'h5000 + 16'h2020);
    endtask

    task automatic t_blk;
        access(1, adr(SLOT, 16'h0000), 6'h3D, 16'h0200);
        access(0, adr(SLOT, 16'h0100), 6'h3B, 0);
        chk("R9 merged enable 3B", r_men, 1);
        chk("R11 ch1 idle under 3B", r_cen, 0);
        chk("R9 merged word 3B", r_data, exp_m);
        access(0, adr(SLOT, 16'h0100), 6'h3F, 0);
        chk("R9 merged enable 3F", r_men, 1);
        chk("R9 merged word 3F", r_data, exp_m);
        access(0, adr(SLOT, 16'h0101), 6'h3F, 0);
        chk("R10 count two", r_data, 2);
        chk("R10 count read no enable", {r_men, r_cen}, 0);
        access(1, adr(SLOT, 16'h0000), 6'h3D, 16'h0055);
        access(0, adr(SLOT, 16'h0101), 6'h3B, 0);
        chk("R10 count kept without bit9", r_data, 2);
        access(1, adr(SLOT, 16'h0000), 6'h3D, 16'h0200);
        access(0, adr(SLOT, 16'h0101), 6'h3B, 0);
        chk("R10 count cleared by bit9", r_data, 0);
        access(0, adr(SLOT, 16'h0100), 6'h3D, 0);
        chk("R11 0x0100 under 3D is ch1", r_cen, 32'h1);
        chk("R11 0x0100 under 3D merged idle", r_men, 0);
        chk("R11 ch1 data", r_data, 16'h5101);
    endtask

    task automatic t_reject;
        logic [9:0] sc;
        sc = sample_count;
        access(1, adr(4'h7, 16'h0300), 6'h3D, 16'h0111);
        chk("R1 foreign slot no ack", r_ack, 0);
        chk("R1 foreign slot ch3 unchanged", thr_of(3), 0);
        access(0, {4'h1, SLOT, 16'h0300}, 6'h3D, 0);
        chk("R1 top nibble no ack/enable", {r_ack, r_cen}, 0);
        access(1, adr(SLOT, 16'h0000), 6'h39, 16'h0601);
        chk("R2 bad modifier no ack", r_ack, 0);
        chk("R2 bad modifier no pulses", {r_fp, r_tp}, 0);
        chk("R2 bad modifier count kept", sample_count, sc);
        access(1, adr(SLOT, 16'h0100), 6'h3B, 16'h0222);
        chk("R2 block modifier write no ack", r_ack, 0);
        chk("R2 block modifier write ch1 kept", thr_of(1), 0);
        access(0, adr(SLOT, 16'h0101), 6'h3D, 0);
        chk("R13 nonzero low byte no ack", {r_ack, r_cen}, 0);
        access(1, adr(SLOT, 16'h2100), 6'h3D, 16'h0333);
        chk("R13 channel 33 no ack", r_ack, 0);
        chk("R13 channel 33 no store", (thresholds == '0), 1);
        access(0, adr(SLOT, 16'h0000), 6'h3D, 0);
        chk("R13 control read no ack", r_ack, 0);
        chk("R3 rejected never acks", r_ack2, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_ctrl;
        t_thr;
        t_chan_read;
        t_blk;
        t_reject;
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule